// File: doc/BRIEF.md
# SPI Pause (Hold) Gating Stage

This stage sits between the four serial-bus pins of a serial memory slave and its command engine. It brings chip-select, serial clock, serial data in and the active-low pause pin into the system clock domain. From them it produces single-cycle enables for the serial clock's rising and falling edges, which drive the engine's shift logic. It also keeps the frame bit position and holds the bit that is currently presented on the serial data output.

When the pause pin falls while the serial clock is low during a selected frame, the stage freezes. Serial clock and data-in are then ignored, the bit position and the output bit are held, and the output enable is withdrawn. A rising pause pin while the serial clock is low thaws the stage. The transfer then continues at exactly the bit where it stopped, and the held output bit is driven again without any extra shift. If chip-select is deasserted while frozen, the stage issues a one-cycle engine reset, and the paused transaction is dropped rather than completed.

Top module: `spi_hold_gate`

## Requirements
- R1: During and after reset with chip-select high, `frozen`, `so_oe`, `eng_rst`, `rise_en` and `fall_en` are 0 and `bit_pos` is 0.
- R2: In a selected, unfrozen frame, each serial clock rise gives exactly one `rise_en` pulse, and `bit_pos` then counts up by one; `si_smp` carries the data-in level at that pulse. Each serial clock fall gives one `fall_en` pulse that loads `so_bit` into `so_q`. `so_oe` is 1.
- R3: A falling pause pin while the serial clock is low in a selected frame sets `frozen` to 1 and clears `so_oe`.
- R4: While `frozen` is 1, serial clock and data-in toggles produce no `rise_en` or `fall_en`, and `bit_pos` and `so_q` keep their values.
- R5: A rising pause pin while the serial clock is low clears `frozen` and sets `so_oe` again with `so_q` unchanged.
- R6: A frame paused in the middle of its address bits and again in the middle of its data bits delivers the same data-in bits and output bits as the same frame sent without pauses.
- R7: Pause pin edges of either direction that happen while the serial clock is high leave the frozen state as it was, even after the serial clock returns low.
- R8: Chip-select rising while frozen gives exactly one `eng_rst` cycle, after which `frozen` and `so_oe` are 0 and `bit_pos` is 0. The next frame starts again from bit 0. A frame that ends without a pause gives no `eng_rst`.
- R9: With chip-select high, pause pin edges never set `frozen`, and serial clock rises give no `rise_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip-select pin, active low |
| sck_pin | input | 1 | Serial clock pin (idles low) |
| si_pin | input | 1 | Serial data-in pin |
| hold_n_pin | input | 1 | Pause pin, active low |
| so_bit | input | 1 | Next output bit offered by the engine |
| rise_en | output | 1 | Engine enable: serial clock rose while running |
| fall_en | output | 1 | Engine enable: serial clock fell while running |
| si_smp | output | 1 | Synchronized data-in level |
| bit_pos | output | CNT_W | Bits received in the current frame |
| frozen | output | 1 | Stage is paused |
| so_q | output | 1 | Bit presented on serial data out |
| so_oe | output | 1 | Output enable for serial data out |
| eng_rst | output | 1 | One-cycle engine reset when the frame is dropped while paused |

## Verification
A pin change passes through two synchronizer flops. It then acts on the state register at the third rising clock edge. The edge enables and `eng_rst` are high during the cycle before that edge, and `frozen`, `so_oe`, `so_q` and `bit_pos` show the result after it. The bench therefore lets at least six system clocks pass after every pin change before it samples on a falling clock edge. Pulse outputs are counted by a monitor on every rising edge, so a pulse can never fall between two samples.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } hold_state_e;

  // positions of the pins inside the synchronized bundle
  localparam int PIN_CNT = 4;
  localparam int IDX_CS  = 0;
  localparam int IDX_SCK = 1;
  localparam int IDX_SI  = 2;
  localparam int IDX_HLD = 3;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = pin_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign lvl_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_lvl,
  input  logic        sck_lvl,
  input  logic        hold_lvl,
  output hold_state_e state_o,
  output logic        rise_en,
  output logic        fall_en,
  output logic        frozen,
  output logic        so_oe,
  output logic        eng_rst
);

  hold_state_e state_q, state_d;
  logic sck_q, hold_q;
  logic sck_rise, sck_fall, hold_fall, hold_rise;

  // previous levels for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      sck_q  <= sck_lvl;
      hold_q <= hold_lvl;
    end
  end

  assign sck_rise  =  sck_lvl  & ~sck_q;
  assign sck_fall  = ~sck_lvl  &  sck_q;
  assign hold_fall = ~hold_lvl &  hold_q;
  assign hold_rise =  hold_lvl & ~hold_q;

  // next state: pause edges only count with the serial clock low
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!cs_lvl) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (cs_lvl)                       state_d = ST_IDLE;
        else if (hold_fall && !sck_lvl)   state_d = ST_PAUSE;
      end
      ST_PAUSE: begin
        if (cs_lvl)                       state_d = ST_IDLE;
        else if (hold_rise && !sck_lvl)   state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    rise_en = (state_q == ST_RUN) && !cs_lvl && sck_rise;
    fall_en = (state_q == ST_RUN) && !cs_lvl && sck_fall;
    frozen  = (state_q == ST_PAUSE);
    so_oe   = (state_q == ST_RUN);
    eng_rst = (state_q == ST_PAUSE) && cs_lvl;
  end

  assign state_o = state_q;

endmodule

// File: rtl/spi_hold_datapath.sv
module spi_hold_datapath
  import spi_hold_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hold_state_e      state_i,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             so_bit,
  output logic [CNT_W-1:0] bit_pos,
  output logic             so_q
);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             pos_we;
  logic             so_d, so_we;

  always_comb begin
    pos_we = 1'b0;
    pos_d  = pos_q;
    if (state_i == ST_IDLE) begin
      pos_we = 1'b1;
      pos_d  = '0;
    end else if (rise_en) begin
      pos_we = 1'b1;
      pos_d  = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_we) pos_q <= pos_d;
  end

  // output bit only moves on a running falling edge
  assign so_we = fall_en;
  assign so_d  = so_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     so_q <= 1'b0;
    else if (so_we) so_q <= so_d;
  end

  assign bit_pos = pos_q;

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_pin,
  input  logic             sck_pin,
  input  logic             si_pin,
  input  logic             hold_n_pin,
  input  logic             so_bit,
  output logic             rise_en,
  output logic             fall_en,
  output logic             si_smp,
  output logic [CNT_W-1:0] bit_pos,
  output logic             frozen,
  output logic             so_q,
  output logic             so_oe,
  output logic             eng_rst
);

  localparam logic [PIN_CNT-1:0] PIN_IDLE =
    PIN_CNT'((1 << IDX_CS) | (1 << IDX_HLD));

  logic [PIN_CNT-1:0] pins, lvl;
  hold_state_e        state;
  logic               cs_s, sck_s, hold_s;

  always_comb begin
    pins          = '0;
    pins[IDX_CS]  = cs_n_pin;
    pins[IDX_SCK] = sck_pin;
    pins[IDX_SI]  = si_pin;
    pins[IDX_HLD] = hold_n_pin;
  end

  spi_hold_sync #(
    .WIDTH   (PIN_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins),
    .lvl_o (lvl)
  );

  assign cs_s   = lvl[IDX_CS];
  assign sck_s  = lvl[IDX_SCK];
  assign hold_s = lvl[IDX_HLD];
  assign si_smp = lvl[IDX_SI];

  spi_hold_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (cs_s),
    .sck_lvl  (sck_s),
    .hold_lvl (hold_s),
    .state_o  (state),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .frozen   (frozen),
    .so_oe    (so_oe),
    .eng_rst  (eng_rst)
  );

  spi_hold_datapath #(
    .CNT_W (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .so_bit  (so_bit),
    .bit_pos (bit_pos),
    .so_q    (so_q)
  );

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck_s,
  input logic             rise_en,
  input logic             fall_en,
  input logic [CNT_W-1:0] bit_pos,
  input logic             frozen,
  input logic             so_q,
  input logic             so_oe,
  input logic             eng_rst
);

  assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(frozen && so_oe));

  assert_enter_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> !$past(sck_s));

  assert_no_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !(rise_en || fall_en));

  assert_pos_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(bit_pos));

  assert_bit_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(so_q));

  assert_exit_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frozen) && so_oe) |-> !$past(sck_s));

  assert_rst_in_pause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> frozen);

  assert_rst_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> (!frozen && !so_oe && !eng_rst));

endmodule

bind spi_hold_gate spi_hold_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sck_s   (sck_s),
  .rise_en (rise_en),
  .fall_en (fall_en),
  .bit_pos (bit_pos),
  .frozen  (frozen),
  .so_q    (so_q),
  .so_oe   (so_oe),
  .eng_rst (eng_rst)
);

// File: tb/spi_hold_gate_test.sv
`timescale 1ns/1ps
module spi_hold_gate_test;

  localparam int          CNT_W   = 6;
  localparam logic [31:0] PATTERN = 32'hC3A5_1E96;
  localparam logic [31:0] WORD    = 32'h03A5_3C96;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n_pin, sck_pin, si_pin, hold_n_pin, so_bit;
  logic rise_en, fall_en, si_smp, frozen, so_q, so_oe, eng_rst;
  logic [CNT_W-1:0] bit_pos;

  int checks = 0;
  int fails  = 0;
  int rise_cnt = 0;
  int fall_cnt = 0;
  int rst_cnt  = 0;
  logic [31:0] rx_word;
  logic [31:0] so_seen;

  always #10 clk = ~clk;

  // engine model: offers a fixed pattern bit chosen by the bit position
  assign so_bit = PATTERN[bit_pos[4:0]];

  spi_hold_gate #(.CNT_W(CNT_W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_pin   (cs_n_pin),
    .sck_pin    (sck_pin),
    .si_pin     (si_pin),
    .hold_n_pin (hold_n_pin),
    .so_bit     (so_bit),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .si_smp     (si_smp),
    .bit_pos    (bit_pos),
    .frozen     (frozen),
    .so_q       (so_q),
    .so_oe      (so_oe),
    .eng_rst    (eng_rst)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (rise_en) begin
        rise_cnt <= rise_cnt + 1;
        rx_word  <= {rx_word[30:0], si_smp};
      end
      if (fall_en) fall_cnt <= fall_cnt + 1;
      if (eng_rst) rst_cnt  <= rst_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sck_pulse();
    sck_pin = 1'b1; settle();
    sck_pin = 1'b0; settle();
  endtask

  // pause with the serial clock low, wiggle the ignored pins, then resume
  task automatic pause_here(input string tag);
    logic [CNT_W-1:0] pos0;
    logic             bit0;
    int               r0, f0;
    pos0 = bit_pos; bit0 = so_q; r0 = rise_cnt; f0 = fall_cnt;
    hold_n_pin = 1'b0; settle();
    chk({"R3 frozen ", tag}, frozen, 1'b1);
    chk({"R3 so_oe off ", tag}, so_oe, 1'b0);
    for (int k = 0; k < 2; k++) begin
      si_pin = ~si_pin;
      sck_pulse();
    end
    chk({"R4 bit_pos held ", tag}, bit_pos, pos0);
    chk({"R4 so_q held ", tag}, so_q, bit0);
    chk({"R4 no edges ", tag}, (rise_cnt - r0) + (fall_cnt - f0), 0);
    hold_n_pin = 1'b1; settle();
    chk({"R5 thawed ", tag}, frozen, 1'b0);
    chk({"R5 so_oe back ", tag}, so_oe, 1'b1);
    chk({"R5 same bit ", tag}, so_q, bit0);
  endtask

  // 32-bit frame; optional pauses before the given bit indices
  task automatic run_frame(input int p1, input int p2,
                           output logic [31:0] rx, output logic [31:0] seen);
    seen = '0;
    cs_n_pin = 1'b0; settle();
    for (int b = 0; b < 32; b++) begin
      if (b == p1 || b == p2) pause_here($sformatf("bit%0d", b));
      si_pin = WORD[31-b];
      settle();
      if (b >= 1) seen[b] = so_q;
      sck_pulse();
    end
    rx = rx_word;
    cs_n_pin = 1'b1; settle();
  endtask

  task automatic t_reset();
    chk("R1 frozen", frozen, 1'b0);
    chk("R1 so_oe", so_oe, 1'b0);
    chk("R1 eng_rst", eng_rst, 1'b0);
    chk("R1 bit_pos", bit_pos, 0);
    chk("R1 enables", {rise_en, fall_en}, 2'b00);
  endtask

  task automatic t_frames();
    logic [31:0] rx_a, so_a, rx_b, so_b, exp_so;
    int r0, f0;
    exp_so = PATTERN & 32'hFFFF_FFFE;
    r0 = rise_cnt; f0 = fall_cnt;
    run_frame(-1, -1, rx_a, so_a);
    chk("R2 rise count", rise_cnt - r0, 32);
    chk("R2 fall count", fall_cnt - f0, 32);
    chk("R2 data in", rx_a, WORD);
    chk("R2 data out", so_a, exp_so);
    chk("R8 no reset on plain end", rst_cnt, 0);
    // pause mid-address (bit 12) and mid-data (bit 27)
    run_frame(12, 27, rx_b, so_b);
    chk("R6 data in matches", rx_b, rx_a);
    chk("R6 data out matches", so_b, so_a);
    chk("R6 no reset", rst_cnt, 0);
  endtask

  task automatic t_high_edges();
    int r0;
    cs_n_pin = 1'b0; settle();
    r0 = rise_cnt;
    sck_pin = 1'b1; settle();
    hold_n_pin = 1'b0; settle();
    chk("R7 fall while high ignored", frozen, 1'b0);
    sck_pin = 1'b0; settle();
    chk("R7 still running", {frozen, so_oe}, 2'b01);
    chk("R7 clock counted", rise_cnt - r0, 1);
    hold_n_pin = 1'b1; settle();
    // now enter properly, then try to leave with the clock high
    hold_n_pin = 1'b0; settle();
    chk("R3 entered", frozen, 1'b1);
    sck_pin = 1'b1; settle();
    hold_n_pin = 1'b1; settle();
    chk("R7 rise while high ignored", frozen, 1'b1);
    sck_pin = 1'b0; settle();
    chk("R7 still paused", frozen, 1'b1);
    hold_n_pin = 1'b0; settle();
    chk("R7 fall while paused", frozen, 1'b1);
    hold_n_pin = 1'b1; settle();
    chk("R5 left with clock low", {frozen, so_oe}, 2'b01);
    cs_n_pin = 1'b1; settle();
  endtask

  task automatic t_drop();
    int rs0;
    rs0 = rst_cnt;
    cs_n_pin = 1'b0; settle();
    for (int b = 0; b < 5; b++) sck_pulse();
    chk("R2 five bits", bit_pos, 5);
    hold_n_pin = 1'b0; settle();
    cs_n_pin = 1'b1; settle();
    chk("R8 one reset", rst_cnt - rs0, 1);
    chk("R8 idle", {frozen, so_oe}, 2'b00);
    chk("R8 bit_pos cleared", bit_pos, 0);
    hold_n_pin = 1'b1; settle();
    cs_n_pin = 1'b0; settle();
    chk("R8 new frame runs", {frozen, so_oe}, 2'b01);
    for (int b = 0; b < 3; b++) sck_pulse();
    chk("R8 restart from zero", bit_pos, 3);
    cs_n_pin = 1'b1; settle();
    chk("R8 single reset only", rst_cnt - rs0, 1);
  endtask

  task automatic t_deselected();
    int r0;
    r0 = rise_cnt;
    hold_n_pin = 1'b0; settle();
    chk("R9 no pause deselected", frozen, 1'b0);
    hold_n_pin = 1'b1; settle();
    sck_pulse();
    chk("R9 no rise deselected", rise_cnt - r0, 0);
    chk("R9 bit_pos zero", bit_pos, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n_pin = 1'b1; sck_pin = 1'b0; si_pin = 1'b0; hold_n_pin = 1'b1;
    rx_word = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_frames();
    t_high_edges();
    t_drop();
    t_deselected();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule